// File: doc/BRIEF.md
# Five-Port Dimension-Order Spike Router

This block is the switching element placed at every tile of a two-dimensional mesh that carries neuron spike events. Each event is one word: a signed x hop count, a signed y hop count and a payload. The payload holds the target input line and the delivery time, and the router never inspects it. The router has five valid/ready ports. Four face the neighbouring tiles and one faces the tile's own core. The core injects spikes through that local port, and packets that reach their destination are handed back to the core through it.

The router first drives the x hop count to zero, then the y hop count. When both are zero the packet is ejected to the local port. Every hop moves the offset one step closer to zero. Each input port has a two-entry FIFO, so a stalled output never drops a packet. Each output port picks among its competing inputs with a rotating priority. A packet that has entered the mesh along the y dimension never turns back into x.

Top module: `spike_router`

## Requirements
- R1: Port index encoding on every vector port is 0 = local, 1 = north, 2 = south, 3 = east, 4 = west. After reset, every output valid is low and every input ready is high.
- R2: A packet word is {dx, dy, payload}, with dx in the top OFF_W bits, dy in the next OFF_W bits and payload in the low PAY_W bits. dx and dy are two's complement. A packet with dx > 0 leaves on east with dx reduced by one. A packet with dx < 0 leaves on west with dx raised by one. In both cases dy and payload are unchanged.
- R3: A packet with dx = 0 and dy > 0 leaves on north with dy reduced by one. One with dx = 0 and dy < 0 leaves on south with dy raised by one.
- R4: A packet with dx = 0 and dy = 0 leaves on the local port with its word unchanged.
- R5: A packet arriving on the north or south input is routed by dy alone and never leaves on east or west. Its dx is passed through unchanged.
- R6: While an output's valid is high and its ready is low, that output's valid stays high and its data stays constant in the next cycle. No packet is lost.
- R7: Each input buffers up to two packets. Its ready is low exactly while two are held, and packets from one input leave in arrival order.
- R8: When several inputs contend for one output, that output serves them in rotating order. After input i is served, the search for the next winner starts at input i+1, wrapping from 4 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input packet valid |
| in_ready | output | 5 | Per-input FIFO has space |
| in_data | input | 5*(2*OFF_W+PAY_W) | Per-input packet words, input p at slice p |
| out_valid | output | 5 | Per-output packet valid |
| out_ready | input | 5 | Per-output downstream accepts |
| out_data | output | 5*(2*OFF_W+PAY_W) | Per-output packet words, output p at slice p |

## Verification
The assertions check four things on every cycle. The grant at each output is one-hot or empty, and it only ever selects a requesting input. A stalled output keeps its valid and its word. A north or south input never requests east or west. No FIFO is popped while empty. Only the bench scenarios can show the offset arithmetic at each output, the choice of output for each sign combination, the two-entry depth and its ready behaviour, the ordering from one input, and the exact rotation order among four contending inputs.

// File: rtl/spike_mesh_pkg.sv
package spike_mesh_pkg;
    localparam int NUM_PORTS = 5;
    localparam int P_LOCAL   = 0;
    localparam int P_NORTH   = 1;
    localparam int P_SOUTH   = 2;
    localparam int P_EAST    = 3;
    localparam int P_WEST    = 4;
endpackage

// File: rtl/spike_fifo.sv
module spike_fifo #(
    parameter int W     = 20,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push;

    assign push_ready = (st_q.cnt != CW'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];
    assign push       = push_valid && push_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);                                   // R7
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));                               // R7
endmodule

// File: rtl/spike_route.sv
module spike_route
    import spike_mesh_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int PAY_W = 12,
    parameter bit Y_ONLY = 1'b0
) (
    input  logic [2*OFF_W+PAY_W-1:0] pkt,
    output logic [NUM_PORTS-1:0]     dir,
    output logic [2*OFF_W+PAY_W-1:0] fwd
);
    localparam int PKW = 2*OFF_W + PAY_W;
    localparam logic signed [OFF_W-1:0] ZERO = '0;
    localparam logic signed [OFF_W-1:0] ONE  = OFF_W'(1);

    logic signed [OFF_W-1:0] dx, dy, ndx, ndy;

    assign dx = pkt[PKW-1 -: OFF_W];
    assign dy = pkt[PKW-OFF_W-1 -: OFF_W];

    always_comb begin
        dir = '0;
        ndx = dx;
        ndy = dy;
        if (!Y_ONLY && dx > ZERO) begin
            dir[P_EAST] = 1'b1;
            ndx = dx - ONE;
        end else if (!Y_ONLY && dx < ZERO) begin
            dir[P_WEST] = 1'b1;
            ndx = dx + ONE;
        end else if (dy > ZERO) begin
            dir[P_NORTH] = 1'b1;
            ndy = dy - ONE;
        end else if (dy < ZERO) begin
            dir[P_SOUTH] = 1'b1;
            ndy = dy + ONE;
        end else begin
            dir[P_LOCAL] = 1'b1;
        end
        fwd = {ndx, ndy, pkt[PAY_W-1:0]};
    end
endmodule

// File: rtl/spike_arb.sv
module spike_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    output logic [N-1:0] grant,
    output logic         any
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          lock;
        logic [N-1:0]  held;
    } arb_st_t;

    arb_st_t       st_d, st_q;
    logic [IW-1:0] gidx;
    logic          found;
    int            idx;

    always_comb begin
        grant = '0;
        found = 1'b0;
        idx   = 0;
        if (st_q.lock) begin
            grant = st_q.held;
        end else begin
            for (int k = 0; k < N; k++) begin
                idx = int'(st_q.ptr) + k;
                if (idx >= N) idx = idx - N;
                if (!found && req[idx]) begin
                    grant[idx] = 1'b1;
                    found = 1'b1;
                end
            end
        end
        gidx = '0;
        for (int j = 0; j < N; j++) begin
            if (grant[j]) gidx = IW'(j);
        end
        any = |grant;

        st_d = st_q;
        if (any && take) begin
            st_d.lock = 1'b0;
            st_d.ptr  = (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
        end else if (any) begin
            st_d.lock = 1'b1;
            st_d.held = grant;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                      // R8
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);                                 // R8
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        any && !take |=> $stable(grant));                      // R6
endmodule

// File: rtl/spike_router.sv
module spike_router
    import spike_mesh_pkg::*;
#(
    parameter int OFF_W      = 4,
    parameter int PAY_W      = 12,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0]                  in_valid,
    output logic [NUM_PORTS-1:0]                  in_ready,
    input  logic [NUM_PORTS*(2*OFF_W+PAY_W)-1:0]  in_data,
    output logic [NUM_PORTS-1:0]                  out_valid,
    input  logic [NUM_PORTS-1:0]                  out_ready,
    output logic [NUM_PORTS*(2*OFF_W+PAY_W)-1:0]  out_data
);
    localparam int PKW = 2*OFF_W + PAY_W;

    logic [NUM_PORTS-1:0] head_valid;
    logic [NUM_PORTS-1:0] pop;
    logic [PKW-1:0]       head  [NUM_PORTS];
    logic [PKW-1:0]       fwd   [NUM_PORTS];
    logic [NUM_PORTS-1:0] dir   [NUM_PORTS];
    logic [NUM_PORTS-1:0] req   [NUM_PORTS];
    logic [NUM_PORTS-1:0] grant [NUM_PORTS];

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
        spike_fifo #(.W(PKW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .push_data  (in_data[i*PKW +: PKW]),
            .pop        (pop[i]),
            .head_valid (head_valid[i]),
            .head_data  (head[i])
        );
        spike_route #(
            .OFF_W  (OFF_W),
            .PAY_W  (PAY_W),
            .Y_ONLY ((i == P_NORTH) || (i == P_SOUTH))
        ) u_route (
            .pkt (head[i]),
            .dir (dir[i]),
            .fwd (fwd[i])
        );
        if ((i == P_NORTH) || (i == P_SOUTH)) begin : g_ychk
            AST_NS_NO_EW: assert property (@(posedge clk) disable iff (!rst_n)
                !dir[i][P_EAST] && !dir[i][P_WEST]);           // R5
        end
    end

    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                req[o][i] = head_valid[i] && dir[i][o];
            end
        end
    end

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        spike_arb #(.N(NUM_PORTS)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[o]),
            .take  (out_ready[o]),
            .grant (grant[o]),
            .any   (out_valid[o])
        );
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=>
            out_valid[o] && $stable(out_data[o*PKW +: PKW]));  // R6
    end

    always_comb begin
        pop      = '0;
        out_data = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (grant[o][i]) begin
                    out_data[o*PKW +: PKW] = fwd[i];
                    if (out_ready[o]) pop[i] = 1'b1;
                end
            end
        end
    end

    AST_EJECT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[P_LOCAL] |-> out_data[P_LOCAL*PKW + PAY_W +: OFF_W] == '0); // R4
endmodule

// File: tb/spike_router_test.sv
`timescale 1ns/1ps
module spike_router_test;
    localparam int NP  = 5;
    localparam int PKW = 20;
    localparam int L = 0, N = 1, S = 2, E = 3, W = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      in_valid = '0;
    logic [NP-1:0]      in_ready;
    logic [NP*PKW-1:0]  in_data = '0;
    logic [NP-1:0]      out_valid;
    logic [NP-1:0]      out_ready = '1;
    logic [NP*PKW-1:0]  out_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spike_router uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [PKW-1:0] pk(int dx, int dy, int pay);
        return {4'(dx), 4'(dy), 12'(pay)};
    endfunction

    function automatic logic [PKW-1:0] outp(int p);
        return out_data[p*PKW +: PKW];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push1(int p, logic [PKW-1:0] d);
        in_valid[p] = 1'b1;
        in_data[p*PKW +: PKW] = d;
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic expect_out(string tag, int p, logic [PKW-1:0] d);
        logic [NP-1:0] ev;
        ev = '0;
        ev[p] = 1'b1;
        chk(out_valid == ev, tag, 32'(out_valid), 32'(ev));
        chk(outp(p) == d, tag, 32'(outp(p)), 32'(d));
    endtask

    task automatic t_reset();
        chk(out_valid == '0, "R1 out_valid", 32'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready", 32'(in_ready), 32'h1f);
    endtask

    task automatic t_route_x();
        push1(L, pk(3, -2, 'h0AB));
        expect_out("R2 east", E, pk(2, -2, 'h0AB));
        @(negedge clk);
        chk(out_valid == '0, "R2 drained", 32'(out_valid), 0);
        push1(L, pk(-1, 4, 'h123));
        expect_out("R2 west", W, pk(0, 4, 'h123));
        @(negedge clk);
    endtask

    task automatic t_route_y();
        push1(W, pk(0, 2, 'h055));
        expect_out("R3 north", N, pk(0, 1, 'h055));
        @(negedge clk);
        push1(E, pk(0, -3, 'h0F0));
        expect_out("R3 south", S, pk(0, -2, 'h0F0));
        @(negedge clk);
    endtask

    task automatic t_eject();
        push1(S, pk(0, 0, 'h777));
        expect_out("R4 local", L, pk(0, 0, 'h777));
        @(negedge clk);
    endtask

    task automatic t_ns_ignore_x();
        push1(N, pk(5, -1, 'h321));
        expect_out("R5 ns keeps dx", S, pk(5, 0, 'h321));
        @(negedge clk);
        push1(S, pk(-3, 0, 'h111));
        expect_out("R5 ns ejects", L, pk(-3, 0, 'h111));
        @(negedge clk);
    endtask

    task automatic t_backpressure();
        out_ready = 5'b10111;
        push1(L, pk(1, 0, 'hA01));
        expect_out("R6 hold 0", E, pk(0, 0, 'hA01));
        push1(L, pk(2, 1, 'hB02));
        expect_out("R6 hold 1", E, pk(0, 0, 'hA01));
        chk(in_ready[L] == 1'b0, "R7 full", 32'(in_ready[L]), 0);
        @(negedge clk);
        expect_out("R6 hold 2", E, pk(0, 0, 'hA01));
        chk(in_ready[L] == 1'b0, "R7 still full", 32'(in_ready[L]), 0);
        out_ready = '1;
        expect_out("R7 first out", E, pk(0, 0, 'hA01));
        @(negedge clk);
        expect_out("R7 second out", E, pk(1, 1, 'hB02));
        chk(in_ready[L] == 1'b1, "R7 space", 32'(in_ready[L]), 1);
        @(negedge clk);
        chk(out_valid == '0, "R6 no loss/no dup", 32'(out_valid), 0);
    endtask

    task automatic t_round_robin();
        out_ready = 5'b11110;
        for (int i = 1; i < NP; i++) begin
            in_valid[i] = 1'b1;
            in_data[i*PKW +: PKW] = pk(0, 0, 'h100 + i);
        end
        @(negedge clk);
        in_valid = '0;
        // last local grant went to south (2), so east (3) leads
        expect_out("R8 first held", L, pk(0, 0, 'h103));
        @(negedge clk);
        expect_out("R8 first stable", L, pk(0, 0, 'h103));
        out_ready = '1;
        @(negedge clk);
        expect_out("R8 second", L, pk(0, 0, 'h104));
        @(negedge clk);
        expect_out("R8 third", L, pk(0, 0, 'h101));
        @(negedge clk);
        expect_out("R8 fourth", L, pk(0, 0, 'h102));
        @(negedge clk);
        chk(out_valid == '0, "R8 drained", 32'(out_valid), 0);
        chk(in_ready == '1, "R7 all empty", 32'(in_ready), 32'h1f);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route_x();
        t_route_y();
        t_eject();
        t_ns_ignore_x();
        t_backpressure();
        t_round_robin();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule